// File: doc/BRIEF.md
# Compressor-Based Wallace Tree Multiplier

This block is a purely combinational unsigned multiplier whose operand width is set by a parameter; 4-bit and 8-bit operands are the intended sizes. It returns the complete double-width product. The work is split into three parts:

- a partial-product array formed with AND gates;
- a column-wise reduction tree that brings every column down to two bits;
- a carry-propagate adder that adds the two surviving rows.

The reduction relies mainly on 4:2 compressors. Each compressor takes four bits of one weight plus a lateral carry-in. It returns a sum at the same weight, and a carry and a lateral carry-out at the next weight. The carry-out of a compressor feeds the carry-in of its partner in the next-higher column. The carry-out never depends on the carry-in, so nothing ripples along a chain. Full adders take columns left with three bits. Half adders take columns left with two bits only where that column still held more than two bits at the start of the stage.

A second parameter selects how the compressor is built. One form is two cascaded full adders. The other is a paired XOR/XNOR stage that steers multiplexers. Both forms give identical results.

Top module: `wallace42_mul`

## Requirements
- R1: For every pair of unsigned N-bit operands, `p_o` equals `a_i * b_i` over all 2N bits, for N = 4 and N = 8.
- R2: The partial-product bit `a_i[i] & b_i[j]` is counted at weight i+j. Operands with one bit set, 1<<i and 1<<j, give a product of exactly 1<<(i+j).
- R3: Nothing carries beyond bit 2N-1. All-ones operands give (2^N-1)^2, and the final adder's carry out and the reduction's column 2N are both 0.
- R4: For every compressor, the count of ones among its four data inputs and its carry-in equals sum + 2*(carry + carry-out).
- R5: A compressor's lateral carry-out is the same whichever value its carry-in takes.
- R6: Parameter STYLE = 0 selects the two-full-adder compressor and STYLE = 1 selects the XOR/XNOR-multiplexer compressor. Both give the same {sum, carry, carry-out} on all 32 input combinations, and so give the same product.
- R7: The reduction tree leaves two rows whose sum, taken modulo 2^(2N+1), equals the full product.
- R8: When either operand is zero, the product is zero.
- R9: In each column, the k-th compressor takes its carry-in from the k-th compressor of the column below, or 0 if that column has no k-th compressor. Any carry-out with no partner above joins the next column's bits as an ordinary bit. Dense operands, which fill every chain, still give the exact product.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | N | Unsigned multiplicand |
| b_i | input | N | Unsigned multiplier |
| p_o | output | 2*N | Unsigned product |

## Verification
Lateral carries moving between compressor columns and a long carry travelling through the final adder can both be active on a single vector. All-ones and alternating dense operands do this, because they fill every column up to its full height. They make every compressor chain carry-outs across columns, and they drive a carry through most of the final adder. Each such vector is judged by comparing the product with an independently computed reference on both compressor styles at once. The in-line checks also confirm that no bit is left above weight 2N-1.

// File: rtl/wtm_pkg.sv
// Shared types and bit-level cells for the compressor-based multiplier.
// Assumes: single-bit operands; every function is purely combinational.
package wtm_pkg;

    // Selects how a 4:2 compressor is built.
    typedef enum logic {
        CMP_FULLADD = 1'b0,
        CMP_XORMUX  = 1'b1
    } cmp_style_e;

    // Outputs of one 4:2 compressor.
    typedef struct packed {
        logic sum;
        logic carry;
        logic cout;
    } c42_t;

    // Full adder: returns {carry, sum}.
    function automatic logic [1:0] fa3(input logic x, input logic y, input logic z);
        return {(x & y) | (x & z) | (y & z), x ^ y ^ z};
    endfunction

    // Half adder: returns {carry, sum}.
    function automatic logic [1:0] ha2(input logic x, input logic y);
        return {x & y, x ^ y};
    endfunction

    // Compressor as two cascaded full adders; cout comes from the first.
    function automatic c42_t c42_fa(input logic [3:0] d, input logic cin);
        logic [1:0] f1;
        logic [1:0] f2;
        c42_t r;
        f1 = fa3(d[0], d[1], d[2]);
        f2 = fa3(f1[0], d[3], cin);
        r.sum   = f2[0];
        r.carry = f2[1];
        r.cout  = f1[1];
        return r;
    endfunction

    // Compressor as an XOR/XNOR pair steering multiplexers.
    function automatic c42_t c42_mux(input logic [3:0] d, input logic cin);
        logic x01;
        logic x23;
        logic n23;
        logic xall;
        c42_t r;
        x01  = d[0] ^ d[1];
        x23  = d[2] ^ d[3];
        n23  = ~x23;
        xall = x01 ? n23 : x23;
        r.sum   = xall ? ~cin : cin;
        r.carry = xall ? cin : d[3];
        r.cout  = x01 ? d[2] : d[0];
        return r;
    endfunction

    // Dispatch on the chosen style.
    function automatic c42_t c42_sel(input cmp_style_e st, input logic [3:0] d, input logic cin);
        return (st == CMP_XORMUX) ? c42_mux(d, cin) : c42_fa(d, cin);
    endfunction

    // Number of ones among the five compressor inputs.
    function automatic int ones5(input logic [3:0] d, input logic cin);
        return int'(d[0]) + int'(d[1]) + int'(d[2]) + int'(d[3]) + int'(cin);
    endfunction

endpackage

// File: rtl/wtm_ppgen.sv
// Partial-product generator: one AND per operand-bit pair.
// Assumes: unsigned operands; pp[i][j] carries weight i+j.
module wtm_ppgen #(
    parameter int unsigned N = 8
) (
    input  logic [N-1:0]        a_i,
    input  logic [N-1:0]        b_i,
    output logic [N-1:0][N-1:0] pp_o
);

    // One AND gate for each (i, j) pair.
    for (genvar gi = 0; gi < N; gi++) begin : g_row
        for (genvar gj = 0; gj < N; gj++) begin : g_col
            assign pp_o[gi][gj] = a_i[gi] & b_i[gj];
        end
    end

endmodule

// File: rtl/wtm_reduce.sv
// Column-wise reduction tree. The partial-product array is cut to two
// rows by 4:2 compressors, chained laterally between columns, plus
// full and half adders for short columns. The structure depends on N
// only, so all loops unroll to fixed wiring.
// Assumes: N >= 2; the output rows are W = 2N+1 bits wide.
module wtm_reduce
    import wtm_pkg::*;
#(
    parameter int unsigned N     = 8,
    parameter cmp_style_e  STYLE = CMP_FULLADD
) (
    input  logic [N-1:0][N-1:0] pp_i,
    output logic [2*N:0]        row0_o,
    output logic [2*N:0]        row1_o
);

    localparam int W    = 2 * N + 1;
    localparam int HMAX = 2 * N + 2;
    localparam int CPC  = (HMAX + 3) / 4;
    localparam int STG  = 2 * N;

    typedef logic [HMAX-1:0] colv_t;

    colv_t cur [W];
    colv_t nxt [W];
    colv_t cov [W];
    int    hc  [W];
    int    hn  [W];
    int    ncmp[W];
    int    k_i;
    int    m_i;
    int    prevn;
    int    rem;
    logic [3:0] quad;
    logic       cin_b;
    logic [1:0] fr;
    c42_t       cr;
    c42_t       cr_alt;

    // Read one bit of a column vector at a variable position.
    function automatic logic bitat(input colv_t v, input int idx);
        colv_t t;
        t = v >> idx;
        return t[0];
    endfunction

    // Build the column array, then run the reduction stages.
    always_comb begin : p_reduce
        for (int c = 0; c < W; c++) begin
            cur[c]  = '0;
            nxt[c]  = '0;
            cov[c]  = '0;
            hc[c]   = 0;
            hn[c]   = 0;
            ncmp[c] = 0;
        end
        k_i = 0; m_i = 0; prevn = 0; rem = 0;
        quad = '0; cin_b = 1'b0; fr = '0; cr = '0; cr_alt = '0;
        for (int i = 0; i < N; i++) begin
            for (int j = 0; j < N; j++) begin
                cur[i+j] = cur[i+j] | (colv_t'(pp_i[i][j]) << hc[i+j]);
                hc[i+j]  = hc[i+j] + 1;
            end
        end
        for (int s = 0; s < STG; s++) begin
            for (int c = 0; c < W; c++) begin
                nxt[c]  = '0;
                hn[c]   = 0;
                cov[c]  = '0;
                ncmp[c] = 0;
            end
            for (int c = 0; c < W; c++) begin
                k_i   = 0;
                m_i   = 0;
                prevn = (c > 0) ? ncmp[c-1] : 0;
                // Compressors while four or more bits remain.
                for (int q = 0; q < CPC; q++) begin
                    if (hc[c] - k_i >= 4) begin
                        quad  = {bitat(cur[c], k_i + 3), bitat(cur[c], k_i + 2),
                                 bitat(cur[c], k_i + 1), bitat(cur[c], k_i)};
                        // R9: partner carry-in from the column below, else 0.
                        cin_b = (m_i < prevn) ? bitat(cov[c-1], m_i) : 1'b0;
                        cr    = c42_sel(STYLE, quad, cin_b);
                        cr_alt = c42_sel(STYLE, quad, ~cin_b);
                        a_r4_conserve: assert (ones5(quad, cin_b) ==
                            int'(cr.sum) + 2 * (int'(cr.carry) + int'(cr.cout)))
                            else $error("R4 compressor count mismatch");
                        a_r5_cout_free: assert (cr.cout == cr_alt.cout)
                            else $error("R5 carry-out depends on carry-in");
                        a_r6_style_match: assert (c42_fa(quad, cin_b) == c42_mux(quad, cin_b))
                            else $error("R6 compressor styles disagree");
                        nxt[c] = nxt[c] | (colv_t'(cr.sum) << hn[c]);
                        hn[c]  = hn[c] + 1;
                        if (c < W - 1) begin
                            nxt[c+1] = nxt[c+1] | (colv_t'(cr.carry) << hn[c+1]);
                            hn[c+1]  = hn[c+1] + 1;
                        end
                        cov[c] = cov[c] | (colv_t'(cr.cout) << m_i);
                        m_i    = m_i + 1;
                        k_i    = k_i + 4;
                    end
                end
                ncmp[c] = m_i;
                // R9: carry-outs with no partner here join as plain bits.
                for (int q = 0; q < CPC; q++) begin
                    if (q >= m_i && q < prevn) begin
                        nxt[c] = nxt[c] | (colv_t'(bitat(cov[c-1], q)) << hn[c]);
                        hn[c]  = hn[c] + 1;
                    end
                end
                rem = hc[c] - k_i;
                if (rem == 3) begin
                    fr = fa3(bitat(cur[c], k_i), bitat(cur[c], k_i + 1), bitat(cur[c], k_i + 2));
                end else if (rem == 2 && hc[c] > 2) begin
                    fr = ha2(bitat(cur[c], k_i), bitat(cur[c], k_i + 1));
                end else begin
                    fr = '0;
                end
                if (rem == 3 || (rem == 2 && hc[c] > 2)) begin
                    nxt[c] = nxt[c] | (colv_t'(fr[0]) << hn[c]);
                    hn[c]  = hn[c] + 1;
                    if (c < W - 1) begin
                        nxt[c+1] = nxt[c+1] | (colv_t'(fr[1]) << hn[c+1]);
                        hn[c+1]  = hn[c+1] + 1;
                    end
                end else begin
                    for (int q = 0; q < 2; q++) begin
                        if (q < rem) begin
                            nxt[c] = nxt[c] | (colv_t'(bitat(cur[c], k_i + q)) << hn[c]);
                            hn[c]  = hn[c] + 1;
                        end
                    end
                end
            end
            for (int c = 0; c < W; c++) begin
                cur[c] = nxt[c];
                hc[c]  = hn[c];
            end
        end
        for (int c = 0; c < W; c++) begin
            row0_o[c] = cur[c][0];
            row1_o[c] = cur[c][1];
        end
    end

    // Checks both compressor styles against each other on all 32 inputs.
    initial begin : p_style_sweep
        logic [4:0] t;
        for (int v = 0; v < 32; v++) begin
            t = v[4:0];
            a_r6_style_exhaustive: assert (c42_fa(t[3:0], t[4]) == c42_mux(t[3:0], t[4]))
                else $error("R6 styles differ on input %0d", v);
        end
    end

endmodule

// File: rtl/wtm_cpa.sv
// Final carry-propagate adder: a ripple chain of full adders that sums
// the two rows left by the reduction tree.
// Assumes: both rows have the same width W.
module wtm_cpa
    import wtm_pkg::*;
#(
    parameter int unsigned W = 17
) (
    input  logic [W-1:0] x_i,
    input  logic [W-1:0] y_i,
    output logic [W-1:0] s_o,
    output logic         co_o
);

    logic [W:0] cy;

    // The chain starts with no carry.
    assign cy[0] = 1'b0;

    // One full adder per bit position.
    for (genvar g = 0; g < W; g++) begin : g_bit
        assign {cy[g+1], s_o[g]} = fa3(x_i[g], y_i[g], cy[g]);
    end

    assign co_o = cy[W];

endmodule

// File: rtl/wallace42_mul.sv
// Top level of the unsigned compressor-based Wallace tree multiplier:
// AND array, then 4:2 compressor reduction, then carry-propagate adder.
// Assumes: unsigned N-bit operands; purely combinational, so no clock
// and no reset.
module wallace42_mul
    import wtm_pkg::*;
#(
    parameter int unsigned N     = 8,
    parameter cmp_style_e  STYLE = CMP_FULLADD
) (
    input  logic [N-1:0]   a_i,
    input  logic [N-1:0]   b_i,
    output logic [2*N-1:0] p_o
);

    localparam int W = 2 * N + 1;

    logic [N-1:0][N-1:0] pp;
    logic [W-1:0]        row0;
    logic [W-1:0]        row1;
    logic [W-1:0]        full;
    logic                cout_top;
    logic [W-1:0]        ref_w;

    wtm_ppgen #(.N(N)) u_ppgen (
        .a_i  (a_i),
        .b_i  (b_i),
        .pp_o (pp)
    );

    wtm_reduce #(.N(N), .STYLE(STYLE)) u_reduce (
        .pp_i   (pp),
        .row0_o (row0),
        .row1_o (row1)
    );

    wtm_cpa #(.W(W)) u_cpa (
        .x_i  (row0),
        .y_i  (row1),
        .s_o  (full),
        .co_o (cout_top)
    );

    // The product is the low 2N bits of the final sum.
    assign p_o = full[2*N-1:0];

    // Guards the reduction rows and the final sum against a reference product.
    always_comb begin : p_guard
        ref_w = W'(a_i) * W'(b_i);
        a_r7_two_rows: assert (W'(row0 + row1) == ref_w)
            else $error("R7 rows do not sum to the product");
        a_r3_no_overflow: assert (full[W-1] == 1'b0 && cout_top == 1'b0)
            else $error("R3 carry beyond bit 2N-1");
        a_r1_product: assert (p_o == ref_w[2*N-1:0])
            else $error("R1 product mismatch");
    end

endmodule

// File: tb/tb_wallace42_mul.sv
// Bench: exhaustive 4x4 and seeded random 8x8 vectors plus directed corner
// cases, on both compressor styles, checked against bench-computed products.
module tb_wallace42_mul;
    import wtm_pkg::*;

    localparam int HALF = 4; // half period of the 8-unit (125 MHz) clock

    logic clk = 1'b0;
    logic [7:0]  a8 = '0, b8 = '0;
    logic [3:0]  a4 = '0, b4 = '0;
    logic [15:0] p8f, p8x;
    logic [7:0]  p4f, p4x;
    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #HALF clk = ~clk;

    wallace42_mul #(.N(8), .STYLE(CMP_FULLADD)) dut (.a_i(a8), .b_i(b8), .p_o(p8f));
    wallace42_mul #(.N(8), .STYLE(CMP_XORMUX))  u8x (.a_i(a8), .b_i(b8), .p_o(p8x));
    wallace42_mul #(.N(4), .STYLE(CMP_FULLADD)) u4f (.a_i(a4), .b_i(b4), .p_o(p4f));
    wallace42_mul #(.N(4), .STYLE(CMP_XORMUX))  u4x (.a_i(a4), .b_i(b4), .p_o(p4x));

    function automatic logic [15:0] ref8(input logic [7:0] x, input logic [7:0] y);
        return 16'(x) * 16'(y);
    endfunction

    function automatic logic [7:0] ref4(input logic [3:0] x, input logic [3:0] y);
        return 8'(x) * 8'(y);
    endfunction

    task automatic chk(input string rq, input logic [15:0] got, input logic [15:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got %0d expected %0d", rq, got, exp);
        end
    endtask

    // Drive at a rising edge, sample at the following falling edge.
    task automatic run8(input string rq, input logic [7:0] x, input logic [7:0] y);
        @(posedge clk);
        a8 = x; b8 = y;
        @(negedge clk);
        chk(rq, p8f, ref8(x, y));
        chk({rq, " style1"}, p8x, ref8(x, y));
    endtask

    task automatic run4(input string rq, input logic [3:0] x, input logic [3:0] y);
        @(posedge clk);
        a4 = x; b4 = y;
        @(negedge clk);
        chk(rq, 16'(p4f), 16'(ref4(x, y)));
        chk({rq, " style1"}, 16'(p4x), 16'(ref4(x, y)));
    endtask

    initial begin : p_main
        logic [7:0] ra, rb;
        void'($urandom(32'h0005_eed1));
        // Initial zero operands: R8 zero product.
        @(negedge clk);
        chk("R8 initial", p8f, 16'd0);
        chk("R8 initial n4", 16'(p4f), 16'd0);
        // R8: one zero operand, the other nonzero.
        run8("R8 a=0", 8'h00, 8'hD7);
        run8("R8 b=0", 8'hFF, 8'h00);
        run4("R8 n4", 4'h0, 4'hF);
        // R3: all-ones operands give the largest product, with no overflow.
        run8("R3 max", 8'hFF, 8'hFF);
        run4("R3 max n4", 4'hF, 4'hF);
        // R2: single-hot operands land at weight i+j.
        for (int i = 0; i < 8; i++) begin
            for (int j = 0; j < 8; j++) begin
                run8("R2 weight", 8'(1 << i), 8'(1 << j));
            end
        end
        // R4 R5 R9: dense patterns fill every compressor chain.
        run8("R9 dense aa", 8'hAA, 8'hFF);
        run8("R9 dense 55", 8'h55, 8'hFF);
        run8("R4 dense", 8'hFE, 8'h7F);
        run8("R5 dense", 8'hF0, 8'hFF);
        // R1 R6 R7: exhaustive 4x4 on both styles.
        for (int x = 0; x < 16; x++) begin
            for (int y = 0; y < 16; y++) begin
                run4("R1 R6 R7 exhaustive n4", 4'(x), 4'(y));
            end
        end
        // R1 R6 R7: seeded random 8x8, biased toward dense operands half the time.
        for (int v = 0; v < 10000; v++) begin
            ra = 8'($urandom);
            rb = 8'($urandom);
            if (v[0]) begin
                ra = ra | 8'($urandom);
                rb = rb | 8'($urandom);
            end
            run8("R1 R6 R7 random n8", ra, rb);
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    // Ends a hung run as a failure.
    initial begin : p_watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule